// File: doc/BRIEF.md
# Shadow Memory Region Access Router

This block sits between the CPU memory path and two backing stores for the upper legacy window of the 1 MB address map, 0xC0000 through 0xFFFFF. For every access that falls in the window it decides, per segment, whether a read is served from an internal shadow RAM or from an external read-only ROM port, and whether a write lands in the shadow RAM or is silently dropped. The decision comes from a bank of 4-bit attribute fields that a configuration register file supplies as one flat vector.

The window is cut into twelve 16 KB segments below 0xF0000 and one 64 KB segment covering 0xF0000 to 0xFFFFF. Read routing and write routing are separate attribute bits, so firmware can copy its ROM into RAM while still executing from ROM, and then turn on RAM reads. The shadow RAM is a synchronous array with byte-lane write enables. Read data comes back from a register one clock after the strobe. The modelled RAM depth per 16 KB slot is a parameter: the default keeps the array small, and a full 256 KB build sets it to 4096 words.

Top module: `shadow_router`

## Requirements
- R1: `hit` is high, in the same cycle as the address, exactly when `cpu_addr` lies in 0xC0000..0xFFFFF. All address bits above bit 19 must be zero.
- R2: Segment n (n = 0..11) covers 0xC0000 + n*0x4000 through 16 KB above that base, and it takes its attribute from `seg_attr[4n+3:4n]`. The range 0xF0000..0xFFFFF is one segment whose attribute is `seg_attr[51:48]`.
- R3: When attribute bit 1 is set, a hitting write raises `ram_we` in the strobe cycle. The shadow RAM then stores the bytes whose `wr_be` bit k is set (bit k selects data bits 8k+7:8k), and the other bytes of the word stay as they were.
- R4: When attribute bit 1 is clear, a hitting write raises `wr_discard`, keeps `ram_we` low, and leaves the shadow RAM contents unchanged. `ram_we` and `wr_discard` are never high together.
- R5: When attribute bit 0 is set, a read returns the shadow RAM word. When it is clear, the read returns `rom_data`, which is sampled for `rom_addr` = (cpu_addr - 0xC0000) >> 2.
- R6: The read-source bit and the write-enable bit act independently. A segment may read ROM while its writes go to RAM, and data written in that state is visible once RAM reads are enabled.
- R7: A hitting read updates `rd_data` and raises `rd_valid` on the next clock edge. `rd_valid` stays high for that one cycle only.
- R8: An access that misses the window raises none of `ram_we`, `wr_discard` or `rd_valid`.
- R9: Reset clears `rd_data` and `rd_valid`. With all attributes at 0, reads return ROM data and writes are discarded. An attribute change applies to the first access presented after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 32 | CPU byte address |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables for the write data |
| seg_attr | input | 52 | Attribute nibbles, 4 bits per segment, top segment highest |
| rom_addr | output | 16 | Word index into the ROM, offset from 0xC0000 |
| rom_data | input | 32 | ROM word for `rom_addr`, combinational |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after a hitting read |
| hit | output | 1 | Address lies in the shadow window |
| ram_we | output | 1 | Shadow RAM write accepted this cycle |
| wr_discard | output | 1 | Write to a protected segment dropped this cycle |

## Verification
The properties check on every cycle that a miss never writes, discards or returns data, that accept and discard never coincide, that `ram_we` only follows a write strobe, and that `rd_valid` tracks a hitting read exactly one cycle later. Whether the right data comes back can only be shown by the bench's scenarios. These cover byte-lane merges, ROM offsets per segment, the 64 KB top segment sharing one attribute, the RAM keeping its contents across a discarded write, and data that was written while reads came from ROM appearing once RAM reads are switched on.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
    localparam int DATA_W   = 32;
    localparam int BE_W     = DATA_W / 8;
    localparam int ATTR_W   = 4;
    localparam int NUM_SEG  = 13;
    localparam int SEG_BITS = 14;           // 16 KB segment
    localparam int WIN_BITS = 18;           // 256 KB window
    localparam int SLOT_N   = 1 << (WIN_BITS - SEG_BITS);
    localparam int TOP_SEG  = NUM_SEG - 1;  // index of the 64 KB segment
    localparam int WORD_W   = WIN_BITS - 2;

    localparam int ATTR_RD_RAM = 0;
    localparam int ATTR_WR_RAM = 1;

    typedef struct packed {
        logic [DATA_W-1:0] rd_data;
        logic              rd_valid;
    } rtr_state_t;
endpackage

// File: rtl/seg_decode.sv
module seg_decode
    import shadow_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]                 addr,
    output logic                              in_win,
    output logic [$clog2(NUM_SEG)-1:0]        seg_idx,
    output logic [WIN_BITS-SEG_BITS-1:0]      slot,
    output logic [WORD_W-1:0]                 word_off
);
    logic [1:0] unused_low;
    assign unused_low = addr[1:0];

    always_comb begin
        in_win   = (addr[ADDR_W-1:20] == '0) && (addr[19:18] == 2'b11);
        slot     = addr[WIN_BITS-1:SEG_BITS];
        word_off = addr[WIN_BITS-1:2];
        if (int'(slot) >= TOP_SEG)
            seg_idx = ($clog2(NUM_SEG))'(TOP_SEG);
        else
            seg_idx = ($clog2(NUM_SEG))'(slot);
    end
endmodule

// File: rtl/attr_select.sv
module attr_select
    import shadow_pkg::*;
(
    input  logic [NUM_SEG*ATTR_W-1:0]  attr_vec,
    input  logic [$clog2(NUM_SEG)-1:0] seg_idx,
    output logic                       rd_ram,
    output logic                       wr_ram
);
    logic [ATTR_W-1:0] nib [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_nib
        assign nib[g] = attr_vec[g*ATTR_W +: ATTR_W];
    end

    logic [ATTR_W-1:0] sel;
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (int'(seg_idx) == i) sel = nib[i];
        end
        rd_ram = sel[ATTR_RD_RAM];
        wr_ram = sel[ATTR_WR_RAM];
    end

    logic [ATTR_W-3:0] unused_hi;
    assign unused_hi = sel[ATTR_W-1:2];
endmodule

// File: rtl/shadow_ram.sv
module shadow_ram
    import shadow_pkg::*;
#(
    parameter int WORDS = 256
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [BE_W-1:0]          be,
    input  logic [$clog2(WORDS)-1:0] idx,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (we && be[b]) mem[idx][b*8 +: 8] <= wdata[b*8 +: 8];
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/shadow_router.sv
module shadow_router
    import shadow_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SLOT_WORDS = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic                      rd_stb,
    input  logic                      wr_stb,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [BE_W-1:0]           wr_be,
    input  logic [NUM_SEG*ATTR_W-1:0] seg_attr,
    output logic [WORD_W-1:0]         rom_addr,
    input  logic [DATA_W-1:0]         rom_data,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      rd_valid,
    output logic                      hit,
    output logic                      ram_we,
    output logic                      wr_discard
);
    localparam int LOC_W   = $clog2(SLOT_WORDS);
    localparam int RAM_WDS = SLOT_N * SLOT_WORDS;
    localparam int IDX_W   = $clog2(RAM_WDS);

    logic [$clog2(NUM_SEG)-1:0]   seg_idx;
    logic [WIN_BITS-SEG_BITS-1:0] slot;
    logic [WORD_W-1:0]            word_off;
    logic                         rd_ram, wr_ram;
    logic [IDX_W-1:0]             ram_idx;
    logic [DATA_W-1:0]            ram_rdata;

    seg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (cpu_addr),
        .in_win  (hit),
        .seg_idx (seg_idx),
        .slot    (slot),
        .word_off(word_off)
    );

    attr_select u_attr (
        .attr_vec(seg_attr),
        .seg_idx (seg_idx),
        .rd_ram  (rd_ram),
        .wr_ram  (wr_ram)
    );

    assign ram_idx  = {slot, word_off[LOC_W-1:0]};
    assign rom_addr = word_off;

    always_comb begin
        ram_we     = wr_stb && hit && wr_ram;
        wr_discard = wr_stb && hit && !wr_ram;
    end

    shadow_ram #(.WORDS(RAM_WDS)) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .be   (wr_be),
        .idx  (ram_idx),
        .wdata(wr_data),
        .rdata(ram_rdata)
    );

    rtr_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = rd_stb && hit;
        if (rd_stb && hit)
            st_d.rd_data = rd_ram ? ram_rdata : rom_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data  = st_q.rd_data;
    assign rd_valid = st_q.rd_valid;

    // R8: a miss never writes, discards or returns data
    a_r8_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (!ram_we && !wr_discard));

    a_r8_miss_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !hit) |=> !rd_valid);

    // R4: accept and discard are exclusive
    a_r4_we_disc_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && wr_discard));

    // R3: RAM writes only follow a write strobe
    a_r3_we_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> wr_stb);

    // R7: one-cycle read latency, valid for a single cycle
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && hit) |=> rd_valid);

    a_r7_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb || !hit) |=> !rd_valid);
endmodule

// File: tb/shadow_router_tb.sv
`timescale 1ns/100ps
module shadow_router_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cpu_addr;
    logic        rd_stb, wr_stb;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;
    logic [51:0] seg_attr;
    logic [15:0] rom_addr;
    logic [31:0] rom_data;
    logic [31:0] rd_data;
    logic        rd_valid, hit, ram_we, wr_discard;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    assign rom_data = 32'hC0DE0000 | {16'h0, rom_addr};

    shadow_router dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .wr_data(wr_data), .wr_be(wr_be), .seg_attr(seg_attr),
        .rom_addr(rom_addr), .rom_data(rom_data), .rd_data(rd_data),
        .rd_valid(rd_valid), .hit(hit), .ram_we(ram_we), .wr_discard(wr_discard)
    );

    typedef struct packed {
        logic        op;       // 1 = write
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [3:0]  be;
        logic        exp_we;
        logic        exp_disc;
        logic [31:0] exp_rd;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h000C0010, 32'h11111111, 4'hF, 1'b1, 1'b0, 32'h0},         // R3
        '{1'b0, 32'h000C0010, 32'h0, 4'h0, 1'b0, 1'b0, 32'h11111111},         // R5
        '{1'b1, 32'h000C0010, 32'hAABBCCDD, 4'h5, 1'b1, 1'b0, 32'h0},         // R3 lanes
        '{1'b0, 32'h000C0010, 32'h0, 4'h0, 1'b0, 1'b0, 32'h11BB11DD},         // R3
        '{1'b1, 32'h000C4020, 32'h22222222, 4'hF, 1'b1, 1'b0, 32'h0},         // R6
        '{1'b0, 32'h000C4020, 32'h0, 4'h0, 1'b0, 1'b0, 32'hC0DE1008},         // R6 ROM
        '{1'b1, 32'h000C8000, 32'h33333333, 4'hF, 1'b0, 1'b1, 32'h0},         // R4
        '{1'b0, 32'h000D0000, 32'h0, 4'h0, 1'b0, 1'b0, 32'hC0DE4000},         // R5
        '{1'b1, 32'h000F8004, 32'h44444444, 4'hF, 1'b1, 1'b0, 32'h0},         // R2
        '{1'b0, 32'h000F8004, 32'h0, 4'h0, 1'b0, 1'b0, 32'h44444444},         // R2
        '{1'b1, 32'h000FFFFC, 32'h55555555, 4'hF, 1'b1, 1'b0, 32'h0},         // R2
        '{1'b0, 32'h000FFFFC, 32'h0, 4'h0, 1'b0, 1'b0, 32'h55555555},         // R2
        '{1'b0, 32'h000EC000, 32'h0, 4'h0, 1'b0, 1'b0, 32'hC0DEB000}          // R2 seg 11
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    // samples the same-cycle flags before the edge and the registered read after it
    logic s_hit, s_we, s_disc, s_rdv;
    logic [31:0] s_rdd;
    task automatic access(input logic op, input logic [31:0] a,
                          input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        cpu_addr = a; wr_data = d; wr_be = b;
        wr_stb = op; rd_stb = !op;
        #1;
        s_hit = hit; s_we = ram_we; s_disc = wr_discard;
        @(negedge clk);
        rd_stb = 1'b0; wr_stb = 1'b0;
        s_rdv = rd_valid; s_rdd = rd_data;
    endtask

    task automatic set_attr(input int seg, input logic [3:0] v);
        @(negedge clk);
        seg_attr[seg*4 +: 4] = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%08h expected=%08h", 32'h1, 32'h0);
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cpu_addr = '0; rd_stb = 0; wr_stb = 0;
        wr_data = '0; wr_be = '0; seg_attr = '0;
        repeat (3) @(negedge clk);
        chk(rd_valid == 1'b0, "R9", "reset rd_valid", {31'h0, rd_valid}, 32'h0);
        chk(rd_data == 32'h0, "R9", "reset rd_data", rd_data, 32'h0);
        rst_n = 1'b1;

        // R9: default attributes -> discard writes, read ROM
        access(1'b1, 32'h000C0010, 32'hDEADBEEF, 4'hF);
        chk(s_disc && !s_we, "R9", "default write discarded", {30'h0, s_we, s_disc}, 32'h1);
        access(1'b0, 32'h000C0010, 32'h0, 4'h0);
        chk(s_rdd == 32'hC0DE0004, "R9", "default read ROM", s_rdd, 32'hC0DE0004);
        chk(s_hit, "R1", "hit at C0010", {31'h0, s_hit}, 32'h1);

        set_attr(0, 4'h3); set_attr(1, 4'h2); set_attr(2, 4'h1); set_attr(12, 4'h3);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].op, VECS[i].addr, VECS[i].wdata, VECS[i].be);
            chk(s_hit, "R1", $sformatf("vec %0d hit", i), {31'h0, s_hit}, 32'h1);
            if (VECS[i].op) begin
                chk(s_we == VECS[i].exp_we && s_disc == VECS[i].exp_disc, "R3/R4",
                    $sformatf("vec %0d we/disc", i), {30'h0, s_we, s_disc},
                    {30'h0, VECS[i].exp_we, VECS[i].exp_disc});
            end else begin
                chk(s_rdv, "R7", $sformatf("vec %0d rd_valid", i), {31'h0, s_rdv}, 32'h1);
                chk(s_rdd == VECS[i].exp_rd, "R5", $sformatf("vec %0d rd_data", i),
                    s_rdd, VECS[i].exp_rd);
            end
        end

        // R7: valid lasts one cycle
        @(negedge clk);
        chk(!rd_valid, "R7", "rd_valid single cycle", {31'h0, rd_valid}, 32'h0);

        // R6: data written while reading ROM appears once RAM reads enabled
        set_attr(1, 4'h1);
        access(1'b0, 32'h000C4020, 32'h0, 4'h0);
        chk(s_rdd == 32'h22222222, "R6", "hidden write visible", s_rdd, 32'h22222222);

        // R9: attribute change applies to the next access
        set_attr(2, 4'h3);
        access(1'b1, 32'h000C8000, 32'h77777777, 4'hF);
        chk(s_we, "R9", "write after enabling", {31'h0, s_we}, 32'h1);
        access(1'b0, 32'h000C8000, 32'h0, 4'h0);
        chk(s_rdd == 32'h77777777, "R9", "read after enabling", s_rdd, 32'h77777777);

        // R4: protected write leaves RAM intact
        set_attr(2, 4'h1);
        access(1'b1, 32'h000C8000, 32'h88888888, 4'hF);
        chk(s_disc && !s_we, "R4", "protected write", {30'h0, s_we, s_disc}, 32'h1);
        access(1'b0, 32'h000C8000, 32'h0, 4'h0);
        chk(s_rdd == 32'h77777777, "R4", "RAM unchanged", s_rdd, 32'h77777777);

        // R1/R8: window edges and misses
        access(1'b0, 32'h000C0000, 32'h0, 4'h0);
        chk(s_hit, "R1", "hit at C0000", {31'h0, s_hit}, 32'h1);
        access(1'b1, 32'h000BFFFC, 32'h99999999, 4'hF);
        chk(!s_hit && !s_we && !s_disc, "R8", "miss below window",
            {29'h0, s_hit, s_we, s_disc}, 32'h0);
        access(1'b0, 32'h00100000, 32'h0, 4'h0);
        chk(!s_hit && !s_rdv, "R8", "miss above window", {30'h0, s_hit, s_rdv}, 32'h0);
        access(1'b0, 32'h800C0000, 32'h0, 4'h0);
        chk(!s_hit && !s_rdv, "R1", "high address bits", {30'h0, s_hit, s_rdv}, 32'h0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule